// File: doc/BRIEF.md
# Cipher Key and IV Register Bank with Busy Lock

This block holds the secret key and the initialization vector used by a block-cipher core. Software writes them through a 32-bit register interface. The key is kept as eight 32-bit words and the IV as four 32-bit words, grouped in left/right pairs. The block presents both to the cipher core as wide buses. The key is right-aligned and masked according to the selected key length. The IV is cut down to 64 bits when the legacy 64-bit-block algorithm is selected.

While the cipher core reports busy, the bank rejects every write, so a key or IV cannot change in the middle of a block. Reads always return the stored words. The algorithm select and the key-size select come from the control logic next to this bank. The bank passes them through to the core together with the assembled values.

Top module: `cipher_keyiv_bank`

## Requirements
- R1: After reset, every key and IV word reads back 0, and `key_out` and `iv_out` are all zero.
- R2: The key words sit at byte offsets 0x20 to 0x3C. Pair n has its left word at 0x20+8n and its right word at 0x24+8n. When `core_busy` is low, a write stores the word, and a read of the same offset returns it.
- R3: The IV words sit at byte offsets 0x40 to 0x4C, with the same left/right pair layout as the key. They are written and read back in the same way as the key words.
- R4: A write to any key or IV offset while `core_busy` is high leaves the stored value unchanged. Reads during busy still return the stored words.
- R5: A write to an offset outside 0x20 to 0x4C changes no stored word, and a read of such an offset returns 0.
- R6: The 256-bit key space is the key words concatenated in offset order. The word at 0x20 occupies bits 255:224 and the word at 0x3C occupies bits 31:0, so key bit 0 (leftmost) lands at bit 255.
- R7: When `cfg_aes`=1 and `cfg_key_size`=2'b00 (128-bit key), `key_out` carries bits 127:0 of the key space, and bits 255:128 are zero.
- R8: When `cfg_aes`=1 and `cfg_key_size`=2'b01 (192-bit key), `key_out` carries bits 191:0 of the key space, and bits 255:192 are zero.
- R9: When `cfg_aes`=1 and `cfg_key_size` is 2'b10 (256-bit key), `key_out` is the whole key space. The unused code 2'b11 is treated the same way.
- R10: When `cfg_aes`=0 (64-bit-block mode), `key_out` is {64'b0, pair 1, pair 2, pair 3}, whatever the value of `cfg_key_size`.
- R11: When `cfg_aes`=1, `iv_out` is {IV 0x40, 0x44, 0x48, 0x4C}. When `cfg_aes`=0, `iv_out` is {64'b0, IV 0x40, IV 0x44}.
- R12: `aes_out` and `key_size_out` follow `cfg_aes` and `cfg_key_size` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register interface |
| bus_addr | input | ADDR_W | Byte address; the two low bits are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| core_busy | input | 1 | Cipher core busy; blocks all writes |
| cfg_aes | input | 1 | 1 selects 128-bit-block mode, 0 selects 64-bit-block mode |
| cfg_key_size | input | 2 | 00 = 128, 01 = 192, 10/11 = 256 bits |
| key_out | output | 256 | Assembled, masked key |
| key_size_out | output | 2 | Key-size select passed to the core |
| aes_out | output | 1 | Algorithm select passed to the core |
| iv_out | output | 128 | Assembled IV with unused bits zero |

## Verification
The assertions take for granted that `core_busy` and the bus inputs settle before each rising edge and stay steady across it. They also assume that no write arrives until the internally synchronized reset has released. The bench changes every input on the falling edge. After releasing reset it waits several cycles before the first access. It raises `core_busy` only on a falling edge, and only between writes, so each write sees a single busy value.

// File: rtl/kiv_pkg.sv
package kiv_pkg;
  localparam int WORD_W    = 32;
  localparam int KEY_WORDS = 8;
  localparam int IV_WORDS  = 4;
  localparam int KEY_BITS  = WORD_W * KEY_WORDS;
  localparam int IV_BITS   = WORD_W * IV_WORDS;
  localparam int KEY_BASE  = 'h20;
  localparam int IV_BASE   = 'h40;

  typedef enum logic [1:0] {
    KSZ_128 = 2'b00,
    KSZ_192 = 2'b01,
    KSZ_256 = 2'b10
  } ksz_e;
endpackage

// File: rtl/kiv_word_bank.sv
module kiv_word_bank #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BASE   = 'h20,
  parameter int NWORDS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     lock,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic                     hit,
  output logic [DATA_W-1:0]        rd_data,
  output logic [NWORDS*DATA_W-1:0] words
);
  localparam int WA_W  = ADDR_W - 2;
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [WA_W-1:0] BASE_W = WA_W'(BASE >> 2);
  localparam logic [WA_W-1:0] SPAN_W = WA_W'(NWORDS);

  logic [WA_W-1:0]   offs;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] word_q [NWORDS];
  logic [DATA_W-1:0] word_d [NWORDS];

  // Offset below the base wraps to a large value, so one compare covers both sides.
  assign offs = addr[ADDR_W-1:2] - BASE_W;
  assign hit  = (offs < SPAN_W);
  assign idx  = offs[IDX_W-1:0];

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    logic load;
    assign load = wr_en & ~lock & hit & (idx == IDX_W'(i));

    always_comb begin
      word_d[i] = word_q[i];
      if (load) word_d[i] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[i] <= '0;
      else        word_q[i] <= word_d[i];
    end

    // Lowest offset ends up in the most significant slice.
    assign words[(NWORDS-1-i)*DATA_W +: DATA_W] = word_q[i];
  end

  assign rd_data = hit ? word_q[idx] : '0;
endmodule

// File: rtl/kiv_assemble.sv
module kiv_assemble
  import kiv_pkg::*;
(
  input  logic                cfg_aes,
  input  logic [1:0]          cfg_key_size,
  input  logic [KEY_BITS-1:0] key_raw,
  input  logic [IV_BITS-1:0]  iv_raw,
  output logic [KEY_BITS-1:0] key_out,
  output logic [IV_BITS-1:0]  iv_out
);
  localparam int SH_128 = KEY_BITS / 2;
  localparam int SH_192 = KEY_BITS / 4;
  localparam logic [KEY_BITS-1:0] ONES = '1;

  logic [KEY_BITS-1:0] key_mask;

  always_comb begin
    if (!cfg_aes) begin
      // Three 64-bit keys from pairs 1..3; pair 0 dropped.
      key_mask = ONES >> SH_192;
    end else begin
      case (cfg_key_size)
        KSZ_128: key_mask = ONES >> SH_128;
        KSZ_192: key_mask = ONES >> SH_192;
        default: key_mask = ONES;
      endcase
    end
  end

  assign key_out = key_raw & key_mask;
  // 64-bit mode uses pair 0 only, moved to the low half.
  assign iv_out  = cfg_aes ? iv_raw : (iv_raw >> (IV_BITS / 2));
endmodule

// File: rtl/cipher_keyiv_bank.sv
module cipher_keyiv_bank
  import kiv_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic                core_busy,
  input  logic                cfg_aes,
  input  logic [1:0]          cfg_key_size,
  output logic [KEY_BITS-1:0] key_out,
  output logic [1:0]          key_size_out,
  output logic                aes_out,
  output logic [IV_BITS-1:0]  iv_out
);
  logic [1:0]          rst_sync_q;
  logic                rst_sync_n;
  logic                key_hit, iv_hit;
  logic [WORD_W-1:0]   key_rd, iv_rd;
  logic [KEY_BITS-1:0] key_raw;
  logic [IV_BITS-1:0]  iv_raw;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  kiv_word_bank #(
    .ADDR_W(ADDR_W), .DATA_W(WORD_W), .BASE(KEY_BASE), .NWORDS(KEY_WORDS)
  ) u_key_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(bus_we), .lock(core_busy),
    .addr(bus_addr), .wdata(bus_wdata), .hit(key_hit), .rd_data(key_rd),
    .words(key_raw)
  );

  kiv_word_bank #(
    .ADDR_W(ADDR_W), .DATA_W(WORD_W), .BASE(IV_BASE), .NWORDS(IV_WORDS)
  ) u_iv_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(bus_we), .lock(core_busy),
    .addr(bus_addr), .wdata(bus_wdata), .hit(iv_hit), .rd_data(iv_rd),
    .words(iv_raw)
  );

  // Banks return zero when not hit, so an OR forms the read mux.
  assign bus_rdata = key_rd | iv_rd;

  kiv_assemble u_assemble (
    .cfg_aes(cfg_aes), .cfg_key_size(cfg_key_size),
    .key_raw(key_raw), .iv_raw(iv_raw),
    .key_out(key_out), .iv_out(iv_out)
  );

  assign key_size_out = cfg_key_size;
  assign aes_out      = cfg_aes;

  logic unused_hits;
  assign unused_hits = key_hit ^ iv_hit;
endmodule

// File: rtl/cipher_keyiv_bank_chk.sv
module cipher_keyiv_bank_chk
  import kiv_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [WORD_W-1:0]   bus_wdata,
  input logic [WORD_W-1:0]   bus_rdata,
  input logic                core_busy,
  input logic                cfg_aes,
  input logic [1:0]          cfg_key_size,
  input logic [KEY_BITS-1:0] key_raw,
  input logic [IV_BITS-1:0]  iv_raw,
  input logic [KEY_BITS-1:0] key_out,
  input logic [IV_BITS-1:0]  iv_out
);
  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_BASE);
  localparam logic [ADDR_W-1:0] END_A = ADDR_W'(IV_BASE + 4 * IV_WORDS);

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    core_busy |=> ($stable(key_raw) && $stable(iv_raw)));

  // R2
  key_store_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && !core_busy && bus_addr == KEY_A)
      |=> key_raw[KEY_BITS-1 -: WORD_W] == $past(bus_wdata));

  // R5
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr < KEY_A || bus_addr >= END_A) |-> bus_rdata == '0);

  // R7
  aes128_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_aes && cfg_key_size == 2'b00) |-> key_out[KEY_BITS-1:KEY_BITS/2] == '0);

  // R10
  des_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_aes |-> (key_out[KEY_BITS-1:KEY_BITS*3/4] == '0
                  && iv_out[IV_BITS-1:IV_BITS/2] == '0));

  // R6
  low_word_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    key_out[WORD_W-1:0] == key_raw[WORD_W-1:0]);
endmodule

bind cipher_keyiv_bank cipher_keyiv_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_busy(core_busy),
  .cfg_aes(cfg_aes), .cfg_key_size(cfg_key_size), .key_raw(key_raw),
  .iv_raw(iv_raw), .key_out(key_out), .iv_out(iv_out)
);

// File: tb/cipher_keyiv_bank_tb.sv
module cipher_keyiv_bank_tb;
  localparam int ADDR_W = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              core_busy, cfg_aes;
  logic [1:0]        cfg_key_size, key_size_out;
  logic [255:0]      key_out;
  logic              aes_out;
  logic [127:0]      iv_out;

  cipher_keyiv_bank #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_busy(core_busy),
    .cfg_aes(cfg_aes), .cfg_key_size(cfg_key_size), .key_out(key_out),
    .key_size_out(key_size_out), .aes_out(aes_out), .iv_out(iv_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] kw [8];
  logic [31:0] ivw [4];

  // {byte address, data}: every key and IV word, in scrambled order.
  localparam logic [63:0] VEC [12] = '{
    {32'h3C, 32'h0F1E2D3C}, {32'h20, 32'hA1B2C3D4}, {32'h44, 32'h11223344},
    {32'h2C, 32'hDEADBEEF}, {32'h30, 32'h55AA55AA}, {32'h4C, 32'h99887766},
    {32'h24, 32'h01234567}, {32'h38, 32'hCAFEF00D}, {32'h40, 32'hFEDCBA98},
    {32'h28, 32'h89ABCDEF}, {32'h48, 32'h13579BDF}, {32'h34, 32'h2468ACE0}
  };

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 8; i++) kw[i] = '0;
    for (int i = 0; i < 4; i++) ivw[i] = '0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (!core_busy) begin
      if (a >= 12'h20 && a < 12'h40) kw[(a - 12'h20) >> 2] = d;
      else if (a >= 12'h40 && a < 12'h50) ivw[(a - 12'h40) >> 2] = d;
    end
  endtask

  task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, 256'(bus_rdata), 256'(exp));
  endtask

  function automatic logic [255:0] exp_key(input logic aes, input logic [1:0] ks);
    logic [255:0] full;
    full = {kw[0], kw[1], kw[2], kw[3], kw[4], kw[5], kw[6], kw[7]};
    if (!aes) return {64'h0, full[191:0]};
    case (ks)
      2'b00:   return {128'h0, full[127:0]};
      2'b01:   return {64'h0, full[191:0]};
      default: return full;
    endcase
  endfunction

  function automatic logic [127:0] exp_iv(input logic aes);
    return aes ? {ivw[0], ivw[1], ivw[2], ivw[3]} : {64'h0, ivw[0], ivw[1]};
  endfunction

  task automatic mode_chk(input string req, input logic aes, input logic [1:0] ks);
    @(negedge clk);
    cfg_aes = aes; cfg_key_size = ks;
    #1;
    chk(req, key_out, exp_key(aes, ks));
    chk("R11", 256'(iv_out), 256'(exp_iv(aes)));
    chk("R12", 256'({aes_out, key_size_out}), 256'({aes, ks}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    core_busy = 1'b0; cfg_aes = 1'b1; cfg_key_size = 2'b10;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd_chk("R1", 12'h20, 32'h0);
    rd_chk("R1", 12'h4C, 32'h0);
    chk("R1", key_out, '0);
    chk("R1", 256'(iv_out), '0);

    // R2 R3: vector table walk
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][43:32], VEC[i][31:0]);
      rd_chk(VEC[i][63:32] < 32'h40 ? "R2" : "R3", VEC[i][43:32], VEC[i][31:0]);
    end

    // R6 R9: full key ordering, including the unused size code
    mode_chk("R6", 1'b1, 2'b10);
    mode_chk("R9", 1'b1, 2'b11);
    chk("R6", 256'(key_out[255:224]), 256'(32'hA1B2C3D4));
    chk("R6", 256'(key_out[31:0]), 256'(32'h0F1E2D3C));
    mode_chk("R7", 1'b1, 2'b00);
    mode_chk("R8", 1'b1, 2'b01);
    mode_chk("R10", 1'b0, 2'b00);
    mode_chk("R10", 1'b0, 2'b10);

    // R4: writes while busy are dropped, reads still work
    @(negedge clk); core_busy = 1'b1;
    wr(12'h20, 32'h00000BAD);
    wr(12'h48, 32'h00000BAD);
    rd_chk("R4", 12'h20, 32'hA1B2C3D4);
    rd_chk("R4", 12'h48, 32'h13579BDF);
    mode_chk("R4", 1'b1, 2'b10);
    @(negedge clk); core_busy = 1'b0;
    wr(12'h20, 32'h600DF00D);
    rd_chk("R4", 12'h20, 32'h600DF00D);

    // R5: unmapped offsets
    wr(12'h50, 32'hFFFFFFFF);
    wr(12'h1C, 32'hFFFFFFFF);
    rd_chk("R5", 12'h50, 32'h0);
    rd_chk("R5", 12'h1C, 32'h0);
    mode_chk("R5", 1'b1, 2'b10);
    mode_chk("R5", 1'b0, 2'b01);

    // R1: reset in mid-run clears everything
    @(negedge clk); rst_n = 1'b0; model_clear();
    #1;
    chk("R1", key_out, '0);
    chk("R1", 256'(iv_out), '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk("R1", 12'h3C, 32'h0);
    rd_chk("R1", 12'h40, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule